// File: doc/BRIEF.md
# Dual-Address Microprogrammed Sequencer

This block is the control half of a datapath. A small microprogram store holds one microword per controller state, and the present state register is the store's only address. Each microword names one qualifier input to test, gives two candidate next addresses (one taken when that qualifier is 1, one when it is 0), and carries a compact output code. A decoder expands that code into one-hot control strobes for the datapath.

Because the qualifier inputs never enter the store address, the store grows with the number of states rather than exponentially with the number of inputs. A state that must branch on several conditions is split into a chain of states, one test each. A state that branches on nothing holds the same address in both next-address fields. An output that should appear only under some condition gets a state of its own. Two strobes that must fire together get a code of their own. The microprogram is a parameter, so each controller is a new image for the same hardware.

Top module: `useq_dual_addr`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 0 after that edge, and `strobe_o` shows the decode of the output code held in microword 0.
- R2: A microword is QSEL_W+2*STATE_W+CODE_W bits wide, with the fields packed from the most significant end as qualifier select, true address, false address, output code (defaults: bits 13:11, 10:7, 6:3 and 2:0). Microword i occupies bits `PROGRAM[i*WORD_W +: WORD_W]`.
- R3: When the select field of the present microword is below NUM_QUAL and the selected bit of `qual_i` is 1 at the edge, the true address is the next state.
- R4: When the select field is below NUM_QUAL and the selected bit is 0 at the edge, the false address is the next state.
- R5: A select field equal to or above NUM_QUAL reads a constant 0, so the false address is always taken, whatever the qualifier inputs are.
- R6: When the true and false addresses of the present microword are equal, that address is the next state for every qualifier pattern.
- R7: `strobe_o` depends only on the present state. Output code 0 drives no strobe, and code c (c of 1 or more) drives only bit c-1.
- R8: A change on `qual_i` between clock edges leaves both `state_o` and `strobe_o` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset to address 0 |
| qual_i | input | NUM_QUAL | Qualifier (condition) inputs tested by the microprogram |
| state_o | output | STATE_W | Present microprogram address |
| strobe_o | output | 2**CODE_W-1 | One-hot control strobes decoded from the present output code |

## Verification
The bench loads its own 16-word microprogram. The image mixes selects that point at real qualifiers, selects past the last qualifier, and words whose two addresses are equal, and it covers every output code. It then runs thousands of cycles with pseudo-random qualifier patterns and occasional resets. Each step is sorted into the true-branch, false-branch, unused-select and equal-address cases, so a swapped branch sense, a wrong field position or a missing constant-0 leg makes the actual path differ from the computed one. Between edges the qualifiers are first driven with the complement of the pattern that will be sampled, which shows whether any output follows the inputs without waiting for a clock.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int DEF_STATE_W = 4;
  localparam int DEF_QSEL_W  = 3;
  localparam int DEF_CODE_W  = 3;
  localparam int DEF_WORD_W  = DEF_QSEL_W + 2 * DEF_STATE_W + DEF_CODE_W;
  localparam int DEF_DEPTH   = 1 << DEF_STATE_W;

  // Default image: computed walk through every state, each select value
  // and each output code; states with index 3 mod 4 branch on nothing.
  function automatic logic [DEF_DEPTH*DEF_WORD_W-1:0] default_program();
    logic [DEF_DEPTH*DEF_WORD_W-1:0] img;
    img = '0;
    for (int s = 0; s < DEF_DEPTH; s++) begin
      logic [DEF_QSEL_W-1:0]  sel;
      logic [DEF_STATE_W-1:0] tgt_t;
      logic [DEF_STATE_W-1:0] tgt_f;
      logic [DEF_CODE_W-1:0]  code;
      sel   = DEF_QSEL_W'(s % (1 << DEF_QSEL_W));
      tgt_t = DEF_STATE_W'((s * 5 + 3) % DEF_DEPTH);
      tgt_f = (s % 4 == 3) ? tgt_t : DEF_STATE_W'((s * 11 + 7) % DEF_DEPTH);
      code  = DEF_CODE_W'((s * 3) % (1 << DEF_CODE_W));
      img[s*DEF_WORD_W +: DEF_WORD_W] = {sel, tgt_t, tgt_f, code};
    end
    return img;
  endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 14,
  parameter logic [(1<<ADDR_W)*WORD_W-1:0] IMAGE = '0
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign mem[i] = IMAGE[i*WORD_W +: WORD_W];
  end

  // Synchronous read: the read register holds the word of the state
  // that the state register takes on the same edge.
  always_ff @(posedge clk) begin
    rd_word <= mem[rd_addr];
  end

endmodule

// File: rtl/useq_qual_mux.sv
module useq_qual_mux #(
  parameter int NUM_QUAL = 6,
  parameter int SEL_W    = 3
) (
  input  logic [NUM_QUAL-1:0] qual,
  input  logic [SEL_W-1:0]    sel,
  output logic                hit
);

  localparam int SPAN = 1 << SEL_W;

  logic [SPAN-1:0] padded;

  for (genvar i = 0; i < SPAN; i++) begin : g_leg
    if (i < NUM_QUAL) begin : g_live
      assign padded[i] = qual[i];
    end else begin : g_tied
      assign padded[i] = 1'b0;
    end
  end

  assign hit = padded[sel];

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr #(
  parameter int ADDR_W = 4
) (
  input  logic              rst,
  input  logic              hit,
  input  logic [ADDR_W-1:0] true_addr,
  input  logic [ADDR_W-1:0] false_addr,
  output logic [ADDR_W-1:0] next_addr
);

  always_comb begin
    if (rst) begin
      next_addr = '0;
    end else if (hit) begin
      next_addr = true_addr;
    end else begin
      next_addr = false_addr;
    end
  end

endmodule

// File: rtl/useq_strobe_dec.sv
module useq_strobe_dec #(
  parameter int CODE_W     = 3,
  parameter int NUM_STROBE = 7
) (
  input  logic [CODE_W-1:0]     code,
  output logic [NUM_STROBE-1:0] strobe
);

  for (genvar i = 0; i < NUM_STROBE; i++) begin : g_line
    assign strobe[i] = (code == CODE_W'(i + 1));
  end

endmodule

// File: rtl/useq_dual_addr.sv
module useq_dual_addr #(
  parameter int STATE_W  = 4,
  parameter int QSEL_W   = 3,
  parameter int CODE_W   = 3,
  parameter int NUM_QUAL = 6,
  parameter logic [(1<<STATE_W)*(QSEL_W+2*STATE_W+CODE_W)-1:0] PROGRAM =
    useq_pkg::default_program()
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_QUAL-1:0]        qual_i,
  output logic [STATE_W-1:0]         state_o,
  output logic [(1<<CODE_W)-2:0]     strobe_o
);

  localparam int WORD_W     = QSEL_W + 2 * STATE_W + CODE_W;
  localparam int NUM_STROBE = (1 << CODE_W) - 1;
  localparam int CODE_LSB   = 0;
  localparam int FALSE_LSB  = CODE_LSB + CODE_W;
  localparam int TRUE_LSB   = FALSE_LSB + STATE_W;
  localparam int QSEL_LSB   = TRUE_LSB + STATE_W;

  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;
  logic [WORD_W-1:0]  uword_q;
  logic               qual_hit;

  logic [QSEL_W-1:0]  f_sel;
  logic [STATE_W-1:0] f_true;
  logic [STATE_W-1:0] f_false;
  logic [CODE_W-1:0]  f_code;

  assign f_sel   = uword_q[QSEL_LSB  +: QSEL_W];
  assign f_true  = uword_q[TRUE_LSB  +: STATE_W];
  assign f_false = uword_q[FALSE_LSB +: STATE_W];
  assign f_code  = uword_q[CODE_LSB  +: CODE_W];

  useq_rom #(
    .ADDR_W (STATE_W),
    .WORD_W (WORD_W),
    .IMAGE  (PROGRAM)
  ) u_rom (
    .clk     (clk),
    .rd_addr (state_d),
    .rd_word (uword_q)
  );

  useq_qual_mux #(
    .NUM_QUAL (NUM_QUAL),
    .SEL_W    (QSEL_W)
  ) u_qmux (
    .qual (qual_i),
    .sel  (f_sel),
    .hit  (qual_hit)
  );

  useq_next_addr #(
    .ADDR_W (STATE_W)
  ) u_next (
    .rst        (rst),
    .hit        (qual_hit),
    .true_addr  (f_true),
    .false_addr (f_false),
    .next_addr  (state_d)
  );

  always_ff @(posedge clk) begin
    state_q <= state_d;
  end

  useq_strobe_dec #(
    .CODE_W     (CODE_W),
    .NUM_STROBE (NUM_STROBE)
  ) u_dec (
    .code   (f_code),
    .strobe (strobe_o)
  );

  assign state_o = state_q;

endmodule

// File: rtl/useq_dual_addr_chk.sv
module useq_dual_addr_chk #(
  parameter int STATE_W  = 4,
  parameter int QSEL_W   = 3,
  parameter int CODE_W   = 3,
  parameter int NUM_QUAL = 6,
  parameter logic [(1<<STATE_W)*(QSEL_W+2*STATE_W+CODE_W)-1:0] PROGRAM = '0
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_QUAL-1:0]    qual_i,
  input logic [STATE_W-1:0]     state_o,
  input logic [(1<<CODE_W)-2:0] strobe_o
);

  localparam int WORD_W     = QSEL_W + 2 * STATE_W + CODE_W;
  localparam int SPAN       = 1 << QSEL_W;
  localparam int NUM_STROBE = (1 << CODE_W) - 1;

  function automatic logic [WORD_W-1:0] word_at(input logic [STATE_W-1:0] a);
    return PROGRAM[a*WORD_W +: WORD_W];
  endfunction

  logic               seen_rst;
  logic               last_rst;
  logic               prev_ok;
  logic [STATE_W-1:0] prev_state;
  logic [SPAN-1:0]    prev_qual;

  always_ff @(posedge clk) begin
    last_rst   <= rst;
    prev_state <= state_o;
    prev_qual  <= SPAN'(qual_i);
    if (rst) begin
      seen_rst <= 1'b1;
      prev_ok  <= 1'b0;
    end else begin
      prev_ok  <= seen_rst;
    end
  end

  logic [WORD_W-1:0]  pw;
  logic [QSEL_W-1:0]  p_sel;
  logic [STATE_W-1:0] p_t;
  logic [STATE_W-1:0] p_f;
  logic [CODE_W-1:0]  c_code;
  logic [NUM_STROBE-1:0] c_exp;

  assign pw     = word_at(prev_state);
  assign p_sel  = pw[WORD_W-1 -: QSEL_W];
  assign p_t    = pw[CODE_W+STATE_W +: STATE_W];
  assign p_f    = pw[CODE_W +: STATE_W];
  assign c_code = word_at(state_o)[CODE_W-1:0];
  assign c_exp  = (c_code == '0) ? '0 : (NUM_STROBE'(1) << (c_code - 1'b1));

  // R1
  a_r1_reset_to_zero: assert property (@(posedge clk) disable iff (rst)
    last_rst |-> (state_o == '0));

  // R2
  a_r2_next_is_listed: assert property (@(posedge clk) disable iff (rst)
    prev_ok |-> (state_o == p_t || state_o == p_f));

  // R3
  a_r3_true_on_one: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && (32'(p_sel) < NUM_QUAL) && prev_qual[p_sel]) |-> (state_o == p_t));

  // R4
  a_r4_false_on_zero: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && (32'(p_sel) < NUM_QUAL) && !prev_qual[p_sel]) |-> (state_o == p_f));

  // R5
  a_r5_unused_sel_false: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && (32'(p_sel) >= NUM_QUAL)) |-> (state_o == p_f));

  // R6
  a_r6_equal_ignores: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && (p_t == p_f)) |-> (state_o == p_t));

  // R7
  a_r7_onehot: assert property (@(posedge clk) disable iff (rst)
    seen_rst |-> $onehot0(strobe_o));

  // R7
  a_r7_code_match: assert property (@(posedge clk) disable iff (rst)
    seen_rst |-> (strobe_o == c_exp));

endmodule

bind useq_dual_addr useq_dual_addr_chk #(
  .STATE_W  (STATE_W),
  .QSEL_W   (QSEL_W),
  .CODE_W   (CODE_W),
  .NUM_QUAL (NUM_QUAL),
  .PROGRAM  (PROGRAM)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .qual_i   (qual_i),
  .state_o  (state_o),
  .strobe_o (strobe_o)
);

// File: tb/useq_dual_addr_tb.sv
`timescale 1ns/1ps
module useq_dual_addr_tb;

  localparam int SW    = 4;
  localparam int QW    = 3;
  localparam int CW    = 3;
  localparam int NQ    = 6;
  localparam int WW    = QW + 2 * SW + CW;
  localparam int DEPTH = 1 << SW;
  localparam int NS    = (1 << CW) - 1;
  localparam int STEPS = 4000;

  // Bench image: fields {select, true, false, code} per R2.
  function automatic logic [WW-1:0] tb_word(input int s);
    int sel, t, f, c;
    sel = (s * 3 + 1) % 8;
    t   = (s * 7 + 2) % DEPTH;
    f   = (s % 5 == 0) ? t : (s + 9) % DEPTH;
    c   = (s * 5) % 8;
    return {QW'(sel), SW'(t), SW'(f), CW'(c)};
  endfunction

  function automatic logic [DEPTH*WW-1:0] tb_image();
    logic [DEPTH*WW-1:0] img;
    img = '0;
    for (int s = 0; s < DEPTH; s++) img[s*WW +: WW] = tb_word(s);
    return img;
  endfunction

  localparam logic [DEPTH*WW-1:0] TB_IMAGE = tb_image();

  function automatic logic [NS-1:0] exp_strobe(input logic [SW-1:0] st);
    int c;
    c = int'(tb_word(int'(st)) % 8);
    if (c == 0) return '0;
    return NS'(1) << (c - 1);
  endfunction

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NQ-1:0] qual = '0;
  logic [SW-1:0] state_o;
  logic [NS-1:0] strobe_o;

  always #2.5 clk = ~clk;

  useq_dual_addr #(
    .STATE_W (SW), .QSEL_W (QW), .CODE_W (CW), .NUM_QUAL (NQ),
    .PROGRAM (TB_IMAGE)
  ) u_dut (
    .clk (clk), .rst (rst), .qual_i (qual),
    .state_o (state_o), .strobe_o (strobe_o)
  );

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  task automatic chk_state(input string tag, input logic [SW-1:0] exp);
    checks++;
    if (state_o !== exp) begin
      failures++;
      $display("FAIL %s state actual=%0d expected=%0d", tag, state_o, exp);
    end
  endtask

  task automatic chk_strobe(input string tag, input logic [NS-1:0] exp);
    checks++;
    if (strobe_o !== exp) begin
      failures++;
      $display("FAIL %s strobe actual=%b expected=%b", tag, strobe_o, exp);
    end
  endtask

  task automatic chk_count(input string tag, input int n);
    checks++;
    if (n == 0) begin
      failures++;
      $display("FAIL %s path count actual=0 expected>0", tag);
    end
  endtask

  initial begin
    logic [15:0]   lfsr;
    logic [SW-1:0] exp_state;
    logic [WW-1:0] w;
    logic [QW-1:0] sel;
    logic [SW-1:0] t, f;
    logic          r;
    string         tag;
    int n_r1, n_r3, n_r4, n_r5, n_r6;
    n_r1 = 0; n_r3 = 0; n_r4 = 0; n_r5 = 0; n_r6 = 0;
    lfsr = 16'hACE1;
    tag  = "R1";

    // Reset hold: state 0 and word-0 strobes (R1, R2); qualifiers ignored (R8).
    repeat (2) @(negedge clk);
    chk_state("R1", '0);
    chk_strobe("R1/R2", exp_strobe('0));
    for (int k = 0; k < 8; k++) begin
      qual = NQ'(k * 9 + 5);
      @(negedge clk);
      chk_state("R8 reset hold", '0);
      chk_strobe("R8 reset hold", exp_strobe('0));
    end
    exp_state = '0;

    for (int i = 0; i < STEPS; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r    = (lfsr[15:10] == 6'd0);
      w    = tb_word(int'(exp_state));
      sel  = w[WW-1 -: QW];
      t    = w[CW+SW +: SW];
      f    = w[CW +: SW];
      // Complement first, then check nothing moved (R8).
      rst  = 1'b0;
      qual = ~lfsr[NQ-1:0];
      #1;
      chk_state("R8", exp_state);
      chk_strobe("R8", exp_strobe(exp_state));
      qual = lfsr[NQ-1:0];
      rst  = r;
      if (r) begin
        tag = "R1"; n_r1++; exp_state = '0;
      end else if (t == f) begin
        tag = "R6"; n_r6++; exp_state = t;
      end else if (int'(sel) >= NQ) begin
        tag = "R5"; n_r5++; exp_state = f;
      end else if (lfsr[sel]) begin
        tag = "R3"; n_r3++; exp_state = t;
      end else begin
        tag = "R4"; n_r4++; exp_state = f;
      end
      @(negedge clk);
      chk_state(tag, exp_state);
      chk_strobe({tag, "/R7"}, exp_strobe(exp_state));
    end
    rst = 1'b0;

    chk_count("R1", n_r1);
    chk_count("R3", n_r3);
    chk_count("R4", n_r4);
    chk_count("R5", n_r5);
    chk_count("R6", n_r6);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule